// File: doc/BRIEF.md
# SPI NOR Flash Command Sequencer

This block sits between a storage client and one SPI bus shared by several NOR flash chips. Each chip has its own active-low select line. The client hands over one request at a time: a read, a page program or a sector erase. A request names one chip with a one-hot mask and gives a 24-bit address inside that chip and a byte count. The sequencer expands the request into the command frames the flash needs and clocks them out through a byte-wide SPI mode-0 shifter. The shifter's bit rate comes from a clock divider. Program data arrives on a byte stream with a valid/ready handshake. Read data leaves on a byte stream marked by a valid strobe. A one-cycle done pulse closes every request.

Program and erase leave a chip busy inside, and the chip stays busy after the bus frame ends. The sequencer keeps one busy flag per chip, raised when it sends that chip a write-enable frame. The next request to a chip whose flag is up first sends a status-polling frame and waits until the chip reports idle. Requests to chips whose flag is down skip polling entirely. A program that would run past the end of its 256-byte page is refused with an error flag. So is an erase whose address is not on a 64 KB boundary. Refused requests cause no bus activity.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset every select line is high, the serial clock is low, done and err are low and req_ready is high.
- R2: Read, program and erase frames start with command byte 0x03, 0x02 and 0xD8 respectively. The command byte is followed by the three address bytes, high byte first, and each frame goes to the chip named in the request.
- R3: Every program or erase frame is preceded by its own write-enable frame (byte 0x06) to the same chip. The select line goes high between the two frames.
- R4: A request to a chip whose busy flag is set starts with a polling frame: byte 0x05, then status bytes read again and again until status bit 0 reads 0. The select line then goes high and the flag clears. The chip is never sent a read, program or erase command while it reports bit 0 set.
- R5: A request to a chip whose busy flag is clear sends no polling frame. Reads and failed requests leave the flag as it was.
- R6: At most one select line is low at any time. The serial clock toggles only while a select line is low.
- R7: A program request takes exactly req_len bytes from the write stream, in order. Data read back afterwards equals the bitwise AND of the old contents and the written bytes.
- R8: A read request delivers exactly req_len bytes on rd_data with rd_valid, in address order.
- R9: A program request with req_len of 0, or with the low address byte plus req_len greater than 256, ends with done and err both high and no bus frame. A request whose select mask is not one-hot is handled the same way.
- R10: An erase request whose low 16 address bits are not all zero ends with done and err high and no bus frame. An aligned erase sets the whole sector to 0xFF.
- R11: done is a one-cycle pulse. req_ready is low from the cycle after a request is taken until done has been given.
- R12: SPI mode 0: the serial clock idles low and the data output holds steady while the serial clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request taken when both high |
| req_op | input | 2 | 0 read, 1 page program, 2 sector erase, 3 refused |
| req_addr | input | ADDR_W | Byte address inside the chip |
| req_cs | input | NUM_CS | One-hot chip choice |
| req_len | input | LEN_W | Byte count for read or program |
| wr_data | input | 8 | Program data byte |
| wr_valid | input | 1 | Program data byte offered |
| wr_ready | output | 1 | Program data byte taken when both high |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | Read data byte strobe |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Request refused, valid with done |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |
| spi_cs_n | output | NUM_CS | Active-low chip selects |

## Verification
The bench attaches a behavioural flash model to each select line. The model holds a chip busy for several status reads after a program or erase. A sequencer that skipped polling, or polled only once, would send a command to a busy chip and be caught by the model. Each request's logged frame sequence is compared with the expected one, so a stray polling frame on an idle chip, or a missing write enable, shows up as a mismatch. Page-edge lengths are probed from both sides: offset 0xFF with length 1 passes, length 2 fails, and a full 256-byte page passes. Misaligned erases and non-one-hot masks must produce an error with no bus frame. Programming over already-programmed bytes must read back the AND of the old and new data, not the new data alone.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_BAD   = 2'd3
  } nor_op_e;

  localparam logic [7:0] CMD_WREN = 8'h06;
  localparam logic [7:0] CMD_RDSR = 8'h05;
  localparam logic [7:0] CMD_READ = 8'h03;
  localparam logic [7:0] CMD_PROG = 8'h02;
  localparam logic [7:0] CMD_SERA = 8'hD8;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CHK,
    S_POLL_CMD,
    S_POLL_RD,
    S_WREN,
    S_GAP,
    S_CMD,
    S_ADDR,
    S_DATA,
    S_FIN
  } seq_state_e;

  function automatic logic frame_state(input seq_state_e s);
    return (s == S_POLL_CMD) || (s == S_POLL_RD) || (s == S_WREN) ||
           (s == S_CMD) || (s == S_ADDR) || (s == S_DATA);
  endfunction

endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int DIV = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx_byte,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic          active;
  logic [CW-1:0] div_cnt;
  logic [2:0]    bit_cnt;
  logic [7:0]    sh_tx;
  logic [7:0]    sh_rx;
  logic          sclk_q;
  logic          mosi_q;
  logic          done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      div_cnt <= '0;
      bit_cnt <= '0;
      sh_tx   <= '0;
      sh_rx   <= '0;
      sclk_q  <= 1'b0;
      mosi_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!active) begin
        if (start) begin
          active  <= 1'b1;
          sh_tx   <= tx_byte;
          mosi_q  <= tx_byte[7];
          div_cnt <= '0;
          bit_cnt <= '0;
          sclk_q  <= 1'b0;
        end
      end else if (div_cnt == CW'(DIV - 1)) begin
        div_cnt <= '0;
        if (!sclk_q) begin
          // rising edge: sample the flash output
          sclk_q <= 1'b1;
          sh_rx  <= {sh_rx[6:0], miso};
        end else begin
          // falling edge: present the next bit or finish
          sclk_q <= 1'b0;
          if (bit_cnt == 3'd7) begin
            active <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + 3'd1;
            sh_tx   <= {sh_tx[6:0], 1'b0};
            mosi_q  <= sh_tx[6];
          end
        end
      end else begin
        div_cnt <= div_cnt + CW'(1);
      end
    end
  end

  assign busy    = active;
  assign done    = done_q;
  assign rx_byte = sh_rx;
  assign sclk    = sclk_q;
  assign mosi    = mosi_q;

endmodule

// File: rtl/nor_busy_track.sv
module nor_busy_track #(
  parameter int NUM_CS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CS-1:0] set_mask,
  input  logic [NUM_CS-1:0] clr_mask,
  output logic [NUM_CS-1:0] busy
);
  logic [NUM_CS-1:0] flags;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)              flags[i] <= 1'b0;
      else if (set_mask[i]) flags[i] <= 1'b1;
      else if (clr_mask[i]) flags[i] <= 1'b0;
    end
  end

  assign busy = flags;

endmodule

// File: rtl/nor_req_guard.sv
module nor_req_guard
  import nor_seq_pkg::*;
#(
  parameter int NUM_CS      = 4,
  parameter int ADDR_W      = 24,
  parameter int LEN_W       = 9,
  parameter int PAGE_BITS   = 8,
  parameter int SECTOR_BITS = 16
) (
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NUM_CS-1:0] cs,
  input  logic [LEN_W-1:0]  len,
  output logic              bad
);
  localparam int SUM_W      = ((LEN_W > PAGE_BITS) ? LEN_W : PAGE_BITS) + 1;
  localparam int PAGE_BYTES = 1 << PAGE_BITS;

  logic             cs_onehot;
  logic             len_zero;
  logic [SUM_W-1:0] page_end;
  logic             prog_bad;
  logic             erase_bad;

  always_comb begin
    cs_onehot = (cs != '0) && ((cs & (cs - NUM_CS'(1))) == '0);
    len_zero  = (len == '0);
    page_end  = SUM_W'(addr[PAGE_BITS-1:0]) + SUM_W'(len);
    prog_bad  = len_zero || (page_end > SUM_W'(PAGE_BYTES));
    erase_bad = (addr[SECTOR_BITS-1:0] != '0);
    case (nor_op_e'(op))
      OP_READ:  bad = !cs_onehot || len_zero;
      OP_PROG:  bad = !cs_onehot || prog_bad;
      OP_ERASE: bad = !cs_onehot || erase_bad;
      default:  bad = 1'b1;
    endcase
  end

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int NUM_CS      = 4,
  parameter int ADDR_W      = 24,
  parameter int LEN_W       = 9,
  parameter int PAGE_BITS   = 8,
  parameter int SECTOR_BITS = 16,
  parameter int CLK_DIV     = 2,
  parameter int GAP_CYC     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [NUM_CS-1:0] req_cs,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [7:0]        wr_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              done,
  output logic              err,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs_n
);
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int GAP_W      = $clog2(GAP_CYC + 1);

  seq_state_e        state, state_d, gap_ret;
  nor_op_e           op_q;
  logic [ADDR_W-1:0] addr_sh;
  logic [NUM_CS-1:0] cs_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  bcnt;
  logic [GAP_W-1:0]  gap_cnt;
  logic              bad_q;
  logic              pend;

  logic              guard_bad;
  logic              sh_busy, sh_done, launch, byte_done;
  logic [7:0]        sh_tx, sh_rx;
  logic [NUM_CS-1:0] busy_vec, set_mask, clr_mask;
  logic              is_read, is_prog, is_erase, busy_hit, sending, poll_clear;

  nor_req_guard #(
    .NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
    .PAGE_BITS(PAGE_BITS), .SECTOR_BITS(SECTOR_BITS)
  ) u_guard (
    .op(req_op), .addr(req_addr), .cs(req_cs), .len(req_len), .bad(guard_bad)
  );

  spi_byte_shifter #(.DIV(CLK_DIV)) u_shift (
    .clk(clk), .rst(rst), .start(launch), .tx_byte(sh_tx),
    .busy(sh_busy), .done(sh_done), .rx_byte(sh_rx),
    .sclk(spi_sclk), .mosi(spi_mosi), .miso(spi_miso)
  );

  nor_busy_track #(.NUM_CS(NUM_CS)) u_busy (
    .clk(clk), .rst(rst), .set_mask(set_mask), .clr_mask(clr_mask), .busy(busy_vec)
  );

  always_comb begin
    is_read    = (op_q == OP_READ);
    is_prog    = (op_q == OP_PROG);
    is_erase   = (op_q == OP_ERASE);
    busy_hit   = |(busy_vec & cs_q);
    sending    = frame_state(state);
    byte_done  = pend && sh_done;
    poll_clear = (state == S_POLL_RD) && byte_done && !sh_rx[0];
    launch     = sending && !pend && !sh_busy &&
                 ((state != S_DATA) || !is_prog || wr_valid);
    wr_ready   = (state == S_DATA) && is_prog && !pend && !sh_busy;
    req_ready  = (state == S_IDLE);
    set_mask   = ((state == S_WREN) && launch) ? cs_q : '0;
    clr_mask   = poll_clear ? cs_q : '0;
  end

  always_comb begin
    case (state)
      S_POLL_CMD: sh_tx = CMD_RDSR;
      S_WREN:     sh_tx = CMD_WREN;
      S_CMD:      sh_tx = is_read ? CMD_READ : (is_prog ? CMD_PROG : CMD_SERA);
      S_ADDR:     sh_tx = addr_sh[ADDR_W-1 -: 8];
      S_DATA:     sh_tx = is_prog ? wr_data : 8'h00;
      default:    sh_tx = 8'h00;
    endcase
  end

  always_comb begin
    state_d = state;
    case (state)
      S_IDLE:     if (req_valid) state_d = guard_bad ? S_FIN : S_CHK;
      S_CHK:      state_d = busy_hit ? S_POLL_CMD : (is_read ? S_CMD : S_WREN);
      S_POLL_CMD: if (byte_done) state_d = S_POLL_RD;
      S_POLL_RD:  if (poll_clear) state_d = S_GAP;
      S_WREN:     if (byte_done) state_d = S_GAP;
      S_GAP:      if (gap_cnt == GAP_W'(GAP_CYC - 1)) state_d = gap_ret;
      S_CMD:      if (byte_done) state_d = S_ADDR;
      S_ADDR:     if (byte_done && bcnt == LEN_W'(ADDR_BYTES - 1))
                    state_d = is_erase ? S_FIN : S_DATA;
      S_DATA:     if (byte_done && bcnt == len_q - LEN_W'(1)) state_d = S_FIN;
      S_FIN:      state_d = S_IDLE;
      default:    state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      gap_ret  <= S_CMD;
      op_q     <= OP_READ;
      addr_sh  <= '0;
      cs_q     <= '0;
      len_q    <= '0;
      bcnt     <= '0;
      gap_cnt  <= '0;
      bad_q    <= 1'b0;
      pend     <= 1'b0;
      spi_cs_n <= '1;
      done     <= 1'b0;
      err      <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      state    <= state_d;
      done     <= 1'b0;
      err      <= 1'b0;
      rd_valid <= 1'b0;
      spi_cs_n <= frame_state(state_d) ? ~cs_q : '1;

      if (byte_done)   pend <= 1'b0;
      else if (launch) pend <= 1'b1;

      case (state)
        S_IDLE: if (req_valid) begin
          op_q    <= nor_op_e'(req_op);
          addr_sh <= req_addr;
          cs_q    <= req_cs;
          len_q   <= req_len;
          bad_q   <= guard_bad;
          bcnt    <= '0;
        end
        S_POLL_RD: if (poll_clear) begin
          gap_ret <= is_read ? S_CMD : S_WREN;
          gap_cnt <= '0;
        end
        S_WREN: if (byte_done) begin
          gap_ret <= S_CMD;
          gap_cnt <= '0;
        end
        S_GAP: gap_cnt <= gap_cnt + GAP_W'(1);
        S_ADDR: if (byte_done) begin
          addr_sh <= {addr_sh[ADDR_W-9:0], 8'h00};
          bcnt    <= (bcnt == LEN_W'(ADDR_BYTES - 1)) ? '0 : bcnt + LEN_W'(1);
        end
        S_DATA: if (byte_done) begin
          bcnt <= bcnt + LEN_W'(1);
          if (is_read) begin
            rd_valid <= 1'b1;
            rd_data  <= sh_rx;
          end
        end
        S_FIN: begin
          done <= 1'b1;
          err  <= bad_q;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              done,
  input logic              err,
  input logic              rd_valid,
  input logic              spi_sclk,
  input logic              spi_mosi,
  input logic [NUM_CS-1:0] spi_cs_n
);

  // R6
  one_select_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(~spi_cs_n) <= 1);

  // R6
  clock_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    spi_sclk |-> !(&spi_cs_n));

  // R12
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (&spi_cs_n) |-> !spi_sclk);

  // R12
  mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R9
  err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> done);

  // R8
  read_in_op_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !req_ready);

endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .err(err), .rd_valid(rd_valid), .spi_sclk(spi_sclk),
  .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n)
);

// File: tb/nor_cmd_seq_bench.sv
module nor_cmd_seq_bench;
  localparam int NCS = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = '0;
  logic [23:0] req_addr = '0;
  logic [3:0]  req_cs = '0;
  logic [8:0]  req_len = '0;
  logic [7:0]  wr_data = '0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic        done;
  logic        err;
  logic        spi_sclk;
  logic        spi_mosi;
  logic        spi_miso = 1'b0;
  logic [3:0]  spi_cs_n;

  nor_cmd_seq u_nor_cmd_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_cs(req_cs), .req_len(req_len),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .done(done), .err(err),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n)
  );

  always #2 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // ---------------- flash model ----------------
  logic [7:0]  fmem [NCS][512];
  int          wip  [NCS];
  bit          wel  [NCS];
  int          m_chip = 0;
  int          m_bi = 0;
  int          m_bit = 0;
  logic [7:0]  m_in = '0;
  logic [7:0]  m_opc = '0;
  logic [23:0] m_fa = '0;
  logic [7:0]  m_out = '0;
  logic [23:0] addr_cap = '0;
  int          cap_chip = -1;
  logic [7:0]  oplog [$];
  bit          prev_low = 1'b0;

  function automatic int sel_idx();
    for (int i = 0; i < NCS; i++) if (!spi_cs_n[i]) return i;
    return 0;
  endfunction

  function automatic logic [7:0] status_byte(input int c);
    logic [7:0] s;
    s = {6'd0, wel[c], wip[c] > 0};
    if (wip[c] > 0) wip[c]--;
    return s;
  endfunction

  task automatic model_byte(input logic [7:0] b);
    if (m_bi == 0) begin
      m_opc = b;
      m_chip = sel_idx();
      oplog.push_back(b);
      case (b)
        8'h06: wel[m_chip] = 1'b1;
        8'h05: m_out = status_byte(m_chip);
        8'h02, 8'hD8: begin
          chk(wel[m_chip], "R3 write enable precedes program/erase", 0, 1);
          chk(wip[m_chip] == 0, "R4 command sent to busy chip", wip[m_chip], 0);
          cap_chip = m_chip;
        end
        8'h03: begin
          chk(wip[m_chip] == 0, "R4 read sent to busy chip", wip[m_chip], 0);
          cap_chip = m_chip;
        end
        default: ;
      endcase
    end else if (m_opc == 8'h05) begin
      m_out = status_byte(m_chip);
    end else if (m_bi <= 3) begin
      m_fa = {m_fa[15:0], b};
      if (m_bi == 3) begin
        addr_cap = m_fa;
        if (m_opc == 8'hD8) for (int k = 0; k < 512; k++) fmem[m_chip][k] = 8'hFF;
        if (m_opc == 8'h03) begin
          m_out = fmem[m_chip][m_fa[8:0]];
          m_fa++;
        end
      end
    end else if (m_opc == 8'h03) begin
      m_out = fmem[m_chip][m_fa[8:0]];
      m_fa++;
    end else if (m_opc == 8'h02) begin
      fmem[m_chip][m_fa[8:0]] = fmem[m_chip][m_fa[8:0]] & b;
      m_fa[7:0] = m_fa[7:0] + 8'd1;
    end
  endtask

  always @(posedge spi_sclk) begin
    m_in = {m_in[6:0], spi_mosi};
    m_bit++;
    if (m_bit == 8) begin
      m_bit = 0;
      model_byte(m_in);
      m_bi++;
    end
  end

  always @(negedge spi_sclk) begin
    spi_miso = m_out[7];
    m_out = {m_out[6:0], 1'b0};
  end

  always @(negedge clk) begin
    if (prev_low && (&spi_cs_n)) begin
      if ((m_opc == 8'h02 || m_opc == 8'hD8) && m_bi >= 4) begin
        wip[m_chip] = 3;
        wel[m_chip] = 1'b0;
      end
      m_bi = 0;
      m_bit = 0;
      m_opc = 8'h00;
    end
    prev_low = !(&spi_cs_n);
  end

  // ---------------- bench reference ----------------
  logic [7:0] shadow [NCS][512];
  bit         busy_exp [NCS];
  logic [7:0] wbuf [256];
  logic [7:0] rbuf [512];
  int         rcount;

  function automatic bit exp_bad(input logic [1:0] op, input logic [3:0] cs,
                                 input logic [23:0] addr, input int len);
    bit onehot = (cs != 0) && ((cs & (cs - 4'd1)) == 0);
    if (!onehot) return 1;
    case (op)
      2'd0: return len == 0;
      2'd1: return (len == 0) || (int'(addr[7:0]) + len > 256);
      2'd2: return addr[15:0] != 0;
      default: return 1;
    endcase
  endfunction

  task automatic run_op(input logic [1:0] op, input logic [3:0] cs,
                        input logic [23:0] addr, input int len, input string tag);
    bit   bad;
    bit   got_err;
    bit   xfer;
    int   wi;
    int   chip;
    logic [7:0] exp_log [$];
    bad = exp_bad(op, cs, addr, len);
    chip = 0;
    for (int i = 0; i < NCS; i++) if (cs[i]) chip = i;
    oplog.delete();
    rcount = 0;
    cap_chip = -1;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_cs = cs; req_addr = addr; req_len = 9'(len);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    wi = 0; xfer = 1'b0; got_err = 1'b0;
    forever begin
      if (xfer) wi++;
      if (op == 2'd1 && wi < len && ($urandom % 4) != 0) begin
        wr_valid = 1'b1; wr_data = wbuf[wi];
      end else wr_valid = 1'b0;
      xfer = wr_valid && wr_ready;
      if (rd_valid && rcount < 512) begin rbuf[rcount] = rd_data; rcount++; end
      if (done) begin got_err = err; break; end
      @(negedge clk);
    end
    wr_valid = 1'b0;
    chk(got_err == bad, {tag, " R9 R10 err flag"}, got_err, bad);
    if (!bad) begin
      if (busy_exp[chip]) exp_log.push_back(8'h05);
      if (op != 2'd0) exp_log.push_back(8'h06);
      exp_log.push_back(op == 2'd0 ? 8'h03 : (op == 2'd1 ? 8'h02 : 8'hD8));
      busy_exp[chip] = (op != 2'd0);
      chk(addr_cap == addr, {tag, " R2 address bytes"}, addr_cap, addr);
      chk(cap_chip == chip, {tag, " R6 selected chip"}, cap_chip, chip);
      if (op == 2'd1) begin
        chk(wi == len, {tag, " R7 bytes taken"}, wi, len);
        for (int i = 0; i < len; i++)
          shadow[chip][(int'(addr[8:0]) & 9'h100) | ((int'(addr[7:0]) + i) & 8'hFF)] &= wbuf[i];
      end
      if (op == 2'd2) for (int k = 0; k < 512; k++) shadow[chip][k] = 8'hFF;
      if (op == 2'd0) begin
        bit same = (rcount == len);
        chk(rcount == len, {tag, " R8 read byte count"}, rcount, len);
        for (int i = 0; i < len && i < rcount; i++)
          if (rbuf[i] !== shadow[chip][(int'(addr[8:0]) + i) & 511]) same = 0;
        chk(same, {tag, " R7 R8 read data"}, same, 1);
      end
    end
    begin
      bit same = (oplog.size() == exp_log.size());
      for (int i = 0; i < exp_log.size() && i < oplog.size(); i++)
        if (oplog[i] != exp_log[i]) same = 0;
      chk(same, {tag, " R2 R3 R4 R5 frame sequence"}, oplog.size(), exp_log.size());
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int c = 0; c < NCS; c++) begin
      wip[c] = 0; wel[c] = 0; busy_exp[c] = 0;
      for (int k = 0; k < 512; k++) begin fmem[c][k] = 8'hFF; shadow[c][k] = 8'hFF; end
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(spi_cs_n == 4'hF, "R1 selects idle high", spi_cs_n, 4'hF);
    chk(spi_sclk == 1'b0, "R1 sclk low", spi_sclk, 0);
    chk(req_ready == 1'b1 && done == 1'b0 && err == 1'b0, "R1 ready/done/err", {req_ready, done, err}, 3'b100);

    // R2 R5 R8: read of a fresh chip, high address
    run_op(2'd0, 4'b0100, 24'h123456, 4, "fresh read");
    // R3 R7: program near page end
    for (int i = 0; i < 16; i++) wbuf[i] = 8'(i * 17);
    run_op(2'd1, 4'b0010, 24'h0000F0, 16, "program");
    // R4: read back after program must poll
    run_op(2'd0, 4'b0010, 24'h0000F0, 16, "read after program");
    // R5: flag cleared, no poll
    run_op(2'd0, 4'b0010, 24'h0000F8, 8, "second read");
    // R9: page crossing, zero length, bad mask, bad op
    run_op(2'd1, 4'b0010, 24'h0000F0, 17, "cross page");
    run_op(2'd1, 4'b0010, 24'h000010, 0, "zero length");
    run_op(2'd0, 4'b0011, 24'h000000, 4, "two selects");
    run_op(2'd3, 4'b0001, 24'h000000, 4, "op code 3");
    // R9 boundaries
    wbuf[0] = 8'h5A; wbuf[1] = 8'hA5;
    run_op(2'd1, 4'b1000, 24'h0000FF, 1, "last byte of page");
    run_op(2'd1, 4'b1000, 24'h0000FF, 2, "one past page");
    for (int i = 0; i < 256; i++) wbuf[i] = 8'($urandom);
    run_op(2'd1, 4'b1000, 24'h000100, 256, "full page");
    run_op(2'd0, 4'b1000, 24'h0000F0, 64, "full page readback");
    // R10
    run_op(2'd2, 4'b0010, 24'h010100, 0, "misaligned erase");
    run_op(2'd2, 4'b0010, 24'h020000, 0, "aligned erase");
    run_op(2'd0, 4'b0010, 24'h0000F0, 16, "read after erase");
    // R7 AND semantics
    wbuf[0] = 8'hF0;
    run_op(2'd1, 4'b0001, 24'h000010, 1, "and first");
    wbuf[0] = 8'h0F;
    run_op(2'd1, 4'b0001, 24'h000010, 1, "and second");
    run_op(2'd0, 4'b0001, 24'h000010, 1, "and readback");
    chk(rbuf[0] == 8'h00, "R7 program only clears bits", rbuf[0], 8'h00);

    // random mix
    for (int n = 0; n < 40; n++) begin
      int sel = $urandom % 8;
      int chip = $urandom % NCS;
      logic [23:0] a = 24'($urandom % 512);
      int len;
      if (sel < 4) begin
        len = 1 + ($urandom % 16);
        run_op(2'd0, 4'(1 << chip), a, len, "random read");
      end else if (sel < 7) begin
        int room = 256 - int'(a[7:0]);
        len = 1 + ($urandom % 16);
        if (len > room) len = room;
        if (sel == 6) len = room + 1 + ($urandom % 4);
        for (int i = 0; i < 16 && i < 256; i++) wbuf[i] = 8'($urandom);
        run_op(2'd1, 4'(1 << chip), a, len, "random program");
      end else begin
        a = {8'($urandom % 4), (($urandom % 3) == 0) ? 16'h0040 : 16'h0000};
        run_op(2'd2, 4'(1 << chip), a, 0, "random erase");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule